// File: doc/BRIEF.md
# Processor Machine-Cycle Clock Selector with Standby Control

This block produces the single-cycle enable that paces the processor's machine cycles. It derives that enable from one of two reference tick inputs. The first is a fast main-clock tick, nominally 4.19 MHz, where a machine cycle lasts 4, 8 or 64 main periods. The second is a slow 32.768 kHz subsystem tick, where a machine cycle always lasts 4 subsystem periods. The whole design runs on one system clock and uses enables only: the reference inputs are one-clock tick strobes and nothing gates a clock.

Two software-visible control words steer the block. The rate word is four bits wide. Its low two bits pick the main-clock machine-cycle length, and its upper two bits form a mode field that entry into standby clears. The system word is also four bits wide. Bit 0 moves the CPU onto the subsystem tick, and bit 3 switches the main oscillator off. Both words are driven out so the CPU can read them back.

Two standby states are supported. The HALT instruction freezes machine cycles until the interrupt controller sends a release pulse. The STOP instruction also turns the main oscillator off. A release pulse brings the oscillator back, but machine cycles resume only after the interval timer reports that the oscillator has settled. A separate prescaler divides the running main tick by a power of two to make a peripheral tick.

Top module: `cpu_clkgen`

## Requirements
- R1: After reset, both control words are zero, the block is running and not in standby, the main oscillator enable is high, and the machine-cycle enable is low. The first machine cycle uses the main tick at 64 periods.
- R2: When main-clock timing is in use, rate bits [1:0] set the cycle length: 00 gives 64 effective main ticks, 01 (reserved) gives 64, 10 gives 8 and 11 gives 4. The machine-cycle enable is a one-clock pulse in the clock cycle that follows the tick that completes the cycle.
- R3: When system word bit 0 is 1, a machine cycle is 4 subsystem ticks and main ticks do not advance it.
- R4: A write that changes the rate or the source takes effect only from the next machine-cycle boundary. The cycle already in progress keeps its original length.
- R5: A HALT strobe while running holds the machine-cycle enable low until an interrupt release pulse arrives. Counting then restarts with a full cycle at the current settings.
- R6: A STOP strobe while running holds the machine-cycle enable low and deasserts the main oscillator enable. A release pulse restores the oscillator enable. Cycles resume only after a later wait-release pulse, and a wait-release pulse that arrives while still stopped has no effect.
- R7: Entering HALT or STOP clears rate-word bits [3:2] and keeps bits [1:0], even if the rate word is written in that same cycle.
- R8: System word bit 3 set to 1 deasserts the main oscillator enable. Main ticks are then ignored by both the machine-cycle counter and the prescaler.
- R9: The peripheral tick is a one-clock pulse after every 2^PERIPH_LOG2 effective main ticks (8 by default).
- R10: If STOP and HALT strobes arrive together, STOP wins. Standby strobes that arrive while already in standby are ignored, and so is a release pulse that arrives while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | One-clock strobe per main reference period |
| sub_tick | input | 1 | One-clock strobe per subsystem reference period |
| rate_we | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 4 | New rate word value |
| sys_we | input | 1 | Write strobe for the system word |
| sys_wdata | input | 4 | New system word value |
| halt_req | input | 1 | HALT instruction strobe |
| stop_req | input | 1 | STOP instruction strobe |
| irq_release | input | 1 | Standby release pulse from the interrupt controller |
| wait_release | input | 1 | Oscillator-settled pulse from the interval timer |
| mcyc_en | output | 1 | Machine-cycle enable pulse for the CPU |
| main_osc_en | output | 1 | Main oscillator enable |
| periph_tick | output | 1 | Prescaled peripheral tick |
| rate_word | output | 4 | Current rate word |
| sys_word | output | 4 | Current system word |

## Verification
The bench writes new rate and source values in the middle of a machine cycle. A design that applies them at once would produce a short or long first cycle, and its pulse spacing would drift away from the reference model. The bench also sends the release pulses in the wrong order: wait-release while still stopped, and an interrupt release while the block is waiting for the oscillator. A design that collapses the two-step STOP exit would restart cycles early. HALT and STOP strobes arrive together and on top of an existing standby, so a wrong priority or a re-entered standby shows up as a stuck enable or a lost oscillator. With the oscillator switched off, the main-clock counter and the prescaler must both freeze, so any leak of main ticks shows up as a stray machine-cycle or peripheral pulse.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int unsigned CTRL_W       = 4;
    localparam int unsigned PHASES       = 4;
    localparam int unsigned PREDIV_SLOW  = 16;
    localparam int unsigned PREDIV_MID   = 2;
    localparam int unsigned PREDIV_FAST  = 1;
    localparam int unsigned LEN_MAX      = PHASES * PREDIV_SLOW;
    localparam int unsigned LEN_W        = $clog2(LEN_MAX + 1);

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STOP = 2'd2,
        ST_WAIT = 2'd3
    } sb_state_e;

    typedef struct packed {
        logic             use_sub;
        logic [LEN_W-1:0] len;
    } cyc_cfg_t;

    function automatic logic [LEN_W-1:0] main_len(input logic [1:0] rate);
        case (rate)
            2'b11:   main_len = LEN_W'(PHASES * PREDIV_FAST);
            2'b10:   main_len = LEN_W'(PHASES * PREDIV_MID);
            default: main_len = LEN_W'(PHASES * PREDIV_SLOW);
        endcase
    endfunction

    function automatic cyc_cfg_t pick_cfg(input logic use_sub, input logic [1:0] rate);
        cyc_cfg_t c;
        c.use_sub = use_sub;
        c.len     = use_sub ? LEN_W'(PHASES) : main_len(rate);
        return c;
    endfunction

endpackage

// File: rtl/clkgen_standby.sv
module clkgen_standby
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_we,
    input  logic [CTRL_W-1:0] rate_wdata,
    input  logic              sys_we,
    input  logic [CTRL_W-1:0] sys_wdata,
    input  logic              halt_req,
    input  logic              stop_req,
    input  logic              irq_release,
    input  logic              wait_release,
    output sb_state_e         state_o,
    output logic [CTRL_W-1:0] rate_o,
    output logic [CTRL_W-1:0] sys_o
);

    sb_state_e         state_q, state_d;
    logic [CTRL_W-1:0] rate_q, rate_d, sys_q, sys_d;
    logic              entering;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req)      state_d = ST_STOP;
                else if (halt_req) state_d = ST_HALT;
            end
            ST_HALT: if (irq_release)  state_d = ST_RUN;
            ST_STOP: if (irq_release)  state_d = ST_WAIT;
            ST_WAIT: if (wait_release) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    assign entering = (state_q == ST_RUN) && (stop_req || halt_req);

    always_comb begin
        rate_d = rate_we ? rate_wdata : rate_q;
        if (entering) rate_d[3:2] = 2'b00;
        sys_d  = sys_we ? sys_wdata : sys_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            rate_q  <= '0;
            sys_q   <= '0;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_d;
            sys_q   <= sys_d;
        end
    end

    assign state_o = state_q;
    assign rate_o  = rate_q;
    assign sys_o   = sys_q;

    // R7
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && (halt_req || stop_req)) |=> (rate_q[3:2] == 2'b00));

    // R10
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && stop_req) |=> (state_q == ST_STOP));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !wait_release) |=> (state_q == ST_WAIT));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && !irq_release) |=> (state_q == ST_STOP));

endmodule

// File: rtl/clkgen_cycle.sv
module clkgen_cycle
    import clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_i,
    input  cyc_cfg_t cfg_req_i,
    input  logic     main_tick_i,
    input  logic     sub_tick_i,
    output logic     mcyc_o
);

    cyc_cfg_t         cfg_q;
    logic [LEN_W-1:0] cnt_q;
    logic             src_tick;
    logic             last_phase;

    assign src_tick   = cfg_q.use_sub ? sub_tick_i : main_tick_i;
    assign last_phase = (cnt_q == LEN_W'(cfg_q.len - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= pick_cfg(1'b0, 2'b00);
            cnt_q  <= '0;
            mcyc_o <= 1'b0;
        end else if (!run_i) begin
            cfg_q  <= cfg_req_i;
            cnt_q  <= '0;
            mcyc_o <= 1'b0;
        end else if (src_tick) begin
            if (last_phase) begin
                cfg_q  <= cfg_req_i;
                cnt_q  <= '0;
                mcyc_o <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                mcyc_o <= 1'b0;
            end
        end else begin
            mcyc_o <= 1'b0;
        end
    end

    // R5
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !mcyc_o);

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        mcyc_o |=> !mcyc_o);

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !(src_tick && last_phase)) |=> $stable(cfg_q));

endmodule

// File: rtl/clkgen_prescale.sv
module clkgen_prescale #(
    parameter int unsigned PERIPH_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic ptick_o
);

    logic [PERIPH_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ptick_o <= 1'b0;
        end else begin
            ptick_o <= tick_i && (&cnt_q);
            if (tick_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    no_idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !ptick_o);

    // R8
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
    import clkgen_pkg::*;
#(
    parameter int unsigned PERIPH_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic              rate_we,
    input  logic [CTRL_W-1:0] rate_wdata,
    input  logic              sys_we,
    input  logic [CTRL_W-1:0] sys_wdata,
    input  logic              halt_req,
    input  logic              stop_req,
    input  logic              irq_release,
    input  logic              wait_release,
    output logic              mcyc_en,
    output logic              main_osc_en,
    output logic              periph_tick,
    output logic [CTRL_W-1:0] rate_word,
    output logic [CTRL_W-1:0] sys_word
);

    sb_state_e         state;
    logic [CTRL_W-1:0] rate_q, sys_q;
    logic              main_eff;
    cyc_cfg_t          cfg_req;

    clkgen_standby u_standby (
        .clk          (clk),
        .rst          (rst),
        .rate_we      (rate_we),
        .rate_wdata   (rate_wdata),
        .sys_we       (sys_we),
        .sys_wdata    (sys_wdata),
        .halt_req     (halt_req),
        .stop_req     (stop_req),
        .irq_release  (irq_release),
        .wait_release (wait_release),
        .state_o      (state),
        .rate_o       (rate_q),
        .sys_o        (sys_q)
    );

    assign main_osc_en = !sys_q[3] && (state != ST_STOP);
    assign main_eff    = main_tick && main_osc_en;
    assign cfg_req     = pick_cfg(sys_q[0], rate_q[1:0]);

    clkgen_cycle u_cycle (
        .clk         (clk),
        .rst         (rst),
        .run_i       (state == ST_RUN),
        .cfg_req_i   (cfg_req),
        .main_tick_i (main_eff),
        .sub_tick_i  (sub_tick),
        .mcyc_o      (mcyc_en)
    );

    clkgen_prescale #(.PERIPH_LOG2(PERIPH_LOG2)) u_prescale (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (main_eff),
        .ptick_o (periph_tick)
    );

    assign rate_word = rate_q;
    assign sys_word  = sys_q;

    // R6
    osc_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && irq_release && !sys_q[3] && !sys_we) |=> main_osc_en);

endmodule

// File: tb/cpu_clkgen_tb.sv
`timescale 1ns/1ps
module cpu_clkgen_tb;

    localparam int PLOG = 3;
    localparam int PDIV = 1 << PLOG;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_tick = 0, sub_tick = 0;
    logic       rate_we = 0, sys_we = 0;
    logic [3:0] rate_wdata = 0, sys_wdata = 0;
    logic       halt_req = 0, stop_req = 0, irq_release = 0, wait_release = 0;
    logic       mcyc_en, main_osc_en, periph_tick;
    logic [3:0] rate_word, sys_word;

    always #4 clk = ~clk;

    cpu_clkgen #(.PERIPH_LOG2(PLOG)) u_dut (
        .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
        .rate_we(rate_we), .rate_wdata(rate_wdata), .sys_we(sys_we), .sys_wdata(sys_wdata),
        .halt_req(halt_req), .stop_req(stop_req), .irq_release(irq_release),
        .wait_release(wait_release), .mcyc_en(mcyc_en), .main_osc_en(main_osc_en),
        .periph_tick(periph_tick), .rate_word(rate_word), .sys_word(sys_word)
    );

    int    checks = 0, fails = 0, cyc = 0;
    int    main_gap = 1;
    bit    main_on = 0, sub_on = 0, done = 0;
    string cur_req = "R1";
    int    ptick_seen = 0;

    // behavioural reference model: 0 run, 1 halt, 2 stop, 3 wait
    int m_state, m_rate, m_sys, m_cnt, m_len, m_src, m_pcnt;
    bit e_mcyc, e_ptick, e_osc;

    function automatic int len_of(int src, int rate);
        if (src != 0) return 4;
        case (rate & 3)
            3: return 4;
            2: return 8;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_rate = 0; m_sys = 0; m_cnt = 0;
            m_len = 64; m_src = 0; m_pcnt = 0;
            e_mcyc = 0; e_ptick = 0; e_osc = 1;
        end else begin
            bit osc, eff, st, entry;
            int nstate;
            osc = ((m_sys & 8) == 0) && (m_state != 2);
            eff = main_tick && osc;
            e_ptick = eff && (m_pcnt == PDIV - 1);
            if (eff) m_pcnt = (m_pcnt + 1) % PDIV;
            e_mcyc = 0;
            if (m_state != 0) begin
                m_cnt = 0;
                m_src = m_sys & 1;
                m_len = len_of(m_src, m_rate);
            end else begin
                st = (m_src != 0) ? sub_tick : eff;
                if (st) begin
                    if (m_cnt == m_len - 1) begin
                        e_mcyc = 1; m_cnt = 0;
                        m_src = m_sys & 1;
                        m_len = len_of(m_src, m_rate);
                    end else m_cnt++;
                end
            end
            nstate = m_state;
            case (m_state)
                0: if (stop_req) nstate = 2; else if (halt_req) nstate = 1;
                1: if (irq_release) nstate = 0;
                2: if (irq_release) nstate = 3;
                default: if (wait_release) nstate = 0;
            endcase
            entry = (m_state == 0) && (stop_req || halt_req);
            if (rate_we) m_rate = rate_wdata;
            if (entry) m_rate = m_rate & 3;
            if (sys_we) m_sys = sys_wdata;
            m_state = nstate;
            e_osc = ((m_sys & 8) == 0) && (m_state != 2);
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("mcyc_en", mcyc_en, e_mcyc);
            chk("main_osc_en", main_osc_en, e_osc);
            chk("periph_tick", periph_tick, e_ptick);
            chk("rate_word", rate_word, m_rate);
            chk("sys_word", sys_word, m_sys);
            if (periph_tick) ptick_seen++;
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            main_tick = main_on && (cyc % main_gap == 0);
            sub_tick  = sub_on && (cyc % 8 == 0);
            rate_we = 0; sys_we = 0; halt_req = 0; stop_req = 0;
            irq_release = 0; wait_release = 0;
        end
    endtask

    task automatic wr_rate(logic [3:0] v);
        rate_wdata = v; rate_we = 1; step(1);
    endtask

    task automatic wr_sys(logic [3:0] v);
        sys_wdata = v; sys_we = 1; step(1);
    endtask

    initial begin
        rst = 1;
        step(3);
        rst = 0;
        step(1);
        cur_req = "R1";
        chk("reset rate_word", rate_word, 0);
        chk("reset sys_word", sys_word, 0);
        chk("reset main_osc_en", main_osc_en, 1);
        chk("reset mcyc_en", mcyc_en, 0);
        main_on = 1; main_gap = 1;
        step(200);
        cur_req = "R2"; wr_rate(4'b0011); step(40);
        cur_req = "R4"; step(2); wr_rate(4'b0010); step(60);
        cur_req = "R2"; wr_rate(4'b0001); step(150);
        wr_rate(4'b0011); main_gap = 3; step(90);
        cur_req = "R3"; sub_on = 1; step(5); wr_sys(4'b0001); step(120);
        cur_req = "R4"; step(3); wr_sys(4'b0000); step(60);
        main_gap = 1;
        cur_req = "R7"; wr_rate(4'b1111); step(3);
        rate_wdata = 4'b1110; rate_we = 1; halt_req = 1; step(1);
        chk("R7 rate after halt entry", rate_word, 4'b0010);
        cur_req = "R5"; step(30);
        cur_req = "R10"; stop_req = 1; step(1); halt_req = 1; step(5);
        cur_req = "R5"; irq_release = 1; step(1); step(50);
        cur_req = "R10"; irq_release = 1; step(1); step(10);
        cur_req = "R6"; wr_rate(4'b1011); step(2);
        stop_req = 1; step(1); step(20);
        chk("R6 osc off in stop", main_osc_en, 0);
        wait_release = 1; step(1); step(10);
        irq_release = 1; step(1);
        chk("R6 osc back after release", main_osc_en, 1);
        step(20);
        irq_release = 1; step(1); step(5);
        wait_release = 1; step(1); step(60);
        cur_req = "R10"; halt_req = 1; stop_req = 1; step(1);
        chk("R10 stop wins osc", main_osc_en, 0);
        step(10); irq_release = 1; step(1); wait_release = 1; step(1); step(40);
        cur_req = "R8"; wr_sys(4'b1000); step(80);
        chk("R8 osc disabled", main_osc_en, 0);
        wr_sys(4'b0000); step(80);
        cur_req = "R9";
        ptick_seen = 0; main_gap = 2; step(160);
        chk("R9 periph count", ptick_seen, 160 / 2 / PDIV);
        step(5);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule